// File: doc/BRIEF.md
# Idle-Mode Clock and Power Sequencer

This block gates the CPU and peripheral clocks of a small microcontroller core in response to a sleep request. On a sleep strobe it picks one of three low-power states. If idle is enabled and the upper clock-select bit is set, it enters an internal-oscillator idle state. If idle is enabled and that bit is clear, it enters an idle state on the current source. If idle is disabled, it enters full sleep. A wake event starts a fixed clock-switch delay. The peripherals stay clocked during that delay, and the CPU clock returns when it ends.

The block also models the internal high-frequency oscillator. It derives the oscillator enable from a frequency-select field and two source bits, and raises both stable flags once a stabilization interval has passed. It models the primary oscillator and its start-up flag in the same way. The low-frequency oscillator enable follows the watchdog and clock-monitor enables. Real oscillators are represented only by enables and counters.

Top module: `idle_clk_seq`

## Requirements
- R1: After reset (rst_ni low) the block is running: cpu_run_o=1, cpu_clk_en_o=1, per_clk_en_o=1, pri_osc_en_o=1, hf_stable_o=0, mf_stable_o=0, osts_o=0.
- R2: While running, a sleep_i strobe with idle_en_i=1 and clk_sel_i[1]=1 enters internal idle from the next cycle: cpu_run_o=0, cpu_clk_en_o=0, per_clk_en_o=1. The value of clk_sel_i[0] has no effect.
- R3: The primary oscillator is deselected by entering internal idle, and while running by clk_sel_i[1]=1 (this selection is registered each cycle). pri_osc_en_o is high only while the primary oscillator is selected and the block is not in full sleep. osts_o is low whenever pri_osc_en_o is low.
- R4: A sleep strobe while running, with idle_en_i=1 and clk_sel_i[1]=0, gates only the CPU clock and leaves pri_osc_en_o unchanged. With idle_en_i=0 the strobe enters full sleep: per_clk_en_o=0, pri_osc_en_o=0, hf_osc_en_o=0.
- R5: hf_osc_en_o=1 exactly when (freq_sel_i != 0 or int_src_i or mid_sel_i) holds and the block is not in full sleep.
- R6: hf_stable_o and mf_stable_o rise once hf_osc_en_o has been high for HF_STAB (default 64) consecutive clock edges. They fall in the same cycle that hf_osc_en_o falls, and stay set through idle if the enable stays high.
- R7: osts_o rises once pri_osc_en_o has been high for OST_DLY (default 16) consecutive edges.
- R8: A wake_i pulse in any idle or sleep state turns per_clk_en_o on at once and holds it on. cpu_run_o and cpu_clk_en_o return exactly SW_DLY (default 8) cycles after the wake edge.
- R9: wake_i has no effect while running or during the switch delay. sleep_i has no effect outside the running state.
- R10: lf_osc_en_o = wdt_en_i or fscm_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| idle_en_i | input | 1 | Idle-on-sleep enable |
| clk_sel_i | input | 2 | System clock select; bit 1 picks the internal path |
| freq_sel_i | input | FSEL_W | Internal oscillator frequency select |
| int_src_i | input | 1 | Internal-source select bit |
| mid_sel_i | input | 1 | Mid-frequency select bit |
| wdt_en_i | input | 1 | Watchdog enable |
| fscm_en_i | input | 1 | Fail-safe clock monitor enable |
| sleep_i | input | 1 | Sleep request strobe |
| wake_i | input | 1 | Wake event |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | 1 | Peripheral clock gate enable |
| pri_osc_en_o | output | 1 | Primary oscillator enable |
| osts_o | output | 1 | Primary oscillator start-up done |
| hf_osc_en_o | output | 1 | Internal high-frequency oscillator enable |
| hf_stable_o | output | 1 | High-frequency output stable |
| mf_stable_o | output | 1 | Mid-frequency output stable |
| lf_osc_en_o | output | 1 | Low-frequency oscillator enable |
| cpu_run_o | output | 1 | CPU running indication |

## Verification
The hardest situation to reach is one where the oscillator is already stable when sleep is requested, followed by a wake pulse that lands inside a running switch delay. The stimulus first holds the frequency select non-zero for longer than the stabilization interval. It then enters internal idle and confirms the flags stay high. Next it repeats wake and sleep strobes a few cycles into the delay and checks that resume timing does not move. A behavioural model tracks each output every cycle, so a shifted counter limit shows up as a single-cycle mismatch.

// File: rtl/idle_clk_pkg.sv
package idle_clk_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE_INT,
    ST_IDLE_CUR,
    ST_SLEEP,
    ST_WAKE
  } pwr_st_e;
endpackage

// File: rtl/osc_stab_timer.sv
module osc_stab_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  // gated by enable so the flag drops in the same cycle as the oscillator
  assign done_o = en_i && (cnt_q == LIM);
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import idle_clk_pkg::*;
#(
  parameter int SW_DLY = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sleep_i,
  input  logic    wake_i,
  input  logic    idle_en_i,
  input  logic    sel_hi_i,
  output pwr_st_e st_o,
  output logic    int_path_o
);
  localparam int SW_W = (SW_DLY > 1) ? $clog2(SW_DLY) : 1;
  localparam logic [SW_W-1:0] SW_LAST = SW_W'(SW_DLY - 1);

  pwr_st_e         st_q;
  logic [SW_W-1:0] sw_q;
  logic            path_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      sw_q   <= '0;
      path_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          path_q <= sel_hi_i;
          if (sleep_i) begin
            if (idle_en_i && sel_hi_i) st_q <= ST_IDLE_INT;
            else if (idle_en_i)        st_q <= ST_IDLE_CUR;
            else                       st_q <= ST_SLEEP;
          end
        end
        ST_IDLE_INT, ST_IDLE_CUR, ST_SLEEP: begin
          if (wake_i) begin
            st_q <= ST_WAKE;
            sw_q <= '0;
          end
        end
        ST_WAKE: begin
          if (sw_q == SW_LAST) st_q <= ST_RUN;
          else                 sw_q <= sw_q + 1'b1;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign st_o       = st_q;
  assign int_path_o = path_q;
endmodule

// File: rtl/idle_clk_seq.sv
module idle_clk_seq
  import idle_clk_pkg::*;
#(
  parameter int FSEL_W  = 3,
  parameter int HF_STAB = 64,
  parameter int OST_DLY = 16,
  parameter int SW_DLY  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_en_i,
  input  logic [1:0]        clk_sel_i,
  input  logic [FSEL_W-1:0] freq_sel_i,
  input  logic              int_src_i,
  input  logic              mid_sel_i,
  input  logic              wdt_en_i,
  input  logic              fscm_en_i,
  input  logic              sleep_i,
  input  logic              wake_i,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              pri_osc_en_o,
  output logic              osts_o,
  output logic              hf_osc_en_o,
  output logic              hf_stable_o,
  output logic              mf_stable_o,
  output logic              lf_osc_en_o,
  output logic              cpu_run_o
);
  pwr_st_e st;
  logic    int_path;
  logic    full_sleep;
  logic    hf_req;
  logic    hf_done;

  pwr_fsm #(.SW_DLY(SW_DLY)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_i    (sleep_i),
    .wake_i     (wake_i),
    .idle_en_i  (idle_en_i),
    .sel_hi_i   (clk_sel_i[1]),
    .st_o       (st),
    .int_path_o (int_path)
  );

  assign full_sleep   = (st == ST_SLEEP);
  assign cpu_run_o    = (st == ST_RUN);
  assign cpu_clk_en_o = cpu_run_o;
  assign per_clk_en_o = !full_sleep;
  assign pri_osc_en_o = !int_path && !full_sleep;

  assign hf_req      = (freq_sel_i != '0) || int_src_i || mid_sel_i;
  assign hf_osc_en_o = hf_req && !full_sleep;
  assign lf_osc_en_o = wdt_en_i || fscm_en_i;

  osc_stab_timer #(.LIMIT(HF_STAB)) u_hf_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (hf_osc_en_o),
    .done_o (hf_done)
  );

  osc_stab_timer #(.LIMIT(OST_DLY)) u_ost_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pri_osc_en_o),
    .done_o (osts_o)
  );

  assign hf_stable_o = hf_done;
  assign mf_stable_o = hf_done;
endmodule

// File: rtl/idle_clk_seq_chk.sv
module idle_clk_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       idle_en_i,
  input logic [1:0] clk_sel_i,
  input logic       wdt_en_i,
  input logic       fscm_en_i,
  input logic       sleep_i,
  input logic       wake_i,
  input logic       cpu_clk_en_o,
  input logic       per_clk_en_o,
  input logic       pri_osc_en_o,
  input logic       osts_o,
  input logic       hf_osc_en_o,
  input logic       hf_stable_o,
  input logic       lf_osc_en_o,
  input logic       cpu_run_o
);
  a_r3_int_idle_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && cpu_run_o && idle_en_i && clk_sel_i[1]) |=>
      (!cpu_clk_en_o && per_clk_en_o && !pri_osc_en_o && !osts_o));

  a_r6_flag_needs_osc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hf_stable_o) |-> $past(hf_osc_en_o));

  a_r8_resume_with_per: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_run_o) |-> $past(per_clk_en_o));

  a_r9_no_sleep_in_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_run_o && per_clk_en_o && sleep_i && !wake_i) |=> per_clk_en_o);

  a_r10_lf_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_en_i || fscm_en_i) |-> lf_osc_en_o);
endmodule

bind idle_clk_seq idle_clk_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .idle_en_i    (idle_en_i),
  .clk_sel_i    (clk_sel_i),
  .wdt_en_i     (wdt_en_i),
  .fscm_en_i    (fscm_en_i),
  .sleep_i      (sleep_i),
  .wake_i       (wake_i),
  .cpu_clk_en_o (cpu_clk_en_o),
  .per_clk_en_o (per_clk_en_o),
  .pri_osc_en_o (pri_osc_en_o),
  .osts_o       (osts_o),
  .hf_osc_en_o  (hf_osc_en_o),
  .hf_stable_o  (hf_stable_o),
  .lf_osc_en_o  (lf_osc_en_o),
  .cpu_run_o    (cpu_run_o)
);

// File: tb/sim_idle_clk_seq.sv
module sim_idle_clk_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HF_STAB = 64;
  localparam int OST_DLY = 16;
  localparam int SW_DLY = 8;

  logic clk = 0, rst_ni = 0;
  logic idle_en = 0, int_src = 0, mid_sel = 0, wdt_en = 0, fscm_en = 0;
  logic sleep = 0, wake = 0;
  logic [1:0] clk_sel = 2'b00;
  logic [2:0] freq_sel = 3'd0;
  logic cpu_clk_en, per_clk_en, pri_osc_en, osts, hf_osc_en, hf_stable, mf_stable, lf_osc_en, cpu_run;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_clk_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .idle_en_i(idle_en), .clk_sel_i(clk_sel),
    .freq_sel_i(freq_sel), .int_src_i(int_src), .mid_sel_i(mid_sel),
    .wdt_en_i(wdt_en), .fscm_en_i(fscm_en), .sleep_i(sleep), .wake_i(wake),
    .cpu_clk_en_o(cpu_clk_en), .per_clk_en_o(per_clk_en), .pri_osc_en_o(pri_osc_en),
    .osts_o(osts), .hf_osc_en_o(hf_osc_en), .hf_stable_o(hf_stable),
    .mf_stable_o(mf_stable), .lf_osc_en_o(lf_osc_en), .cpu_run_o(cpu_run)
  );

  // reference model: 0 run, 1 idle internal, 2 idle current, 3 full sleep, 4 wake delay
  int m_st = 0, m_sw = 0, m_hf = 0, m_ost = 0;
  bit m_path = 0;

  function automatic bit m_hf_en();
    return ((freq_sel != 0) || int_src || mid_sel) && (m_st != 3);
  endfunction
  function automatic bit m_pri_en();
    return !m_path && (m_st != 3);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_sw = 0; m_hf = 0; m_ost = 0; m_path = 0;
    end else begin
      m_hf  = m_hf_en()  ? ((m_hf  < HF_STAB) ? m_hf + 1  : m_hf)  : 0;
      m_ost = m_pri_en() ? ((m_ost < OST_DLY) ? m_ost + 1 : m_ost) : 0;
      if (m_st == 0) begin
        m_path = clk_sel[1];
        if (sleep) m_st = (idle_en && clk_sel[1]) ? 1 : (idle_en ? 2 : 3);
      end else if (m_st == 4) begin
        if (m_sw == SW_DLY - 1) m_st = 0; else m_sw++;
      end else if (wake) begin
        m_st = 4; m_sw = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d act=%0b exp=%0b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    chk("R2 R4 R8 R9 cpu_run", cpu_run, m_st == 0);
    chk("R2 R8 cpu_clk_en", cpu_clk_en, m_st == 0);
    chk("R4 R8 per_clk_en", per_clk_en, m_st != 3);
    chk("R3 R4 pri_osc_en", pri_osc_en, m_pri_en());
    chk("R3 R7 osts", osts, m_pri_en() && m_ost == OST_DLY);
    chk("R5 hf_osc_en", hf_osc_en, m_hf_en());
    chk("R6 hf_stable", hf_stable, m_hf_en() && m_hf == HF_STAB);
    chk("R6 mf_stable", mf_stable, m_hf_en() && m_hf == HF_STAB);
    chk("R10 lf_osc_en", lf_osc_en, wdt_en || fscm_en);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask
  task automatic pulse_sleep();
    sleep = 1; idle(1); sleep = 0;
  endtask
  task automatic pulse_wake();
    wake = 1; idle(1); wake = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_ni = 1;
    #1;
    // R1 reset state
    chk("R1 cpu_run", cpu_run, 1); chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 per_clk_en", per_clk_en, 1); chk("R1 pri_osc_en", pri_osc_en, 1);
    chk("R1 hf_stable", hf_stable, 0); chk("R1 mf_stable", mf_stable, 0);
    chk("R1 osts", osts, 0);
    // stable oscillator before internal idle, lower select bit set (ignored, R2)
    freq_sel = 3'd3; idle(HF_STAB + 6);
    idle_en = 1; clk_sel = 2'b11; idle(2);
    pulse_sleep(); idle(1);
    chk("R2 internal idle", cpu_run, 0);
    chk("R6 flags kept in idle", hf_stable, 1);
    pulse_sleep(); idle(5);          // R9 sleep while idle
    pulse_wake(); idle(2);
    pulse_wake(); pulse_sleep();     // R9 during switch delay
    idle(SW_DLY + 4);
    chk("R8 resumed", cpu_run, 1);
    // idle on current source
    clk_sel = 2'b00; idle(OST_DLY + 3);
    pulse_wake();                    // R9 wake while running
    pulse_sleep(); idle(4);
    chk("R4 pri kept", pri_osc_en, 1);
    pulse_wake(); idle(SW_DLY + 3);
    // full sleep
    idle_en = 0; wdt_en = 1; pulse_sleep(); idle(3);
    chk("R4 full sleep per", per_clk_en, 0);
    chk("R10 lf in sleep", lf_osc_en, 1);
    pulse_wake(); idle(SW_DLY + HF_STAB + 4);
    // enable sources one by one
    freq_sel = 0; wdt_en = 0; fscm_en = 1; idle(3);
    chk("R5 no source", hf_osc_en, 0);
    mid_sel = 1; idle(HF_STAB + 3);
    mid_sel = 0; int_src = 1; idle(HF_STAB / 2);
    int_src = 0; fscm_en = 0; clk_sel = 2'b10; idle_en = 1; freq_sel = 3'd4;
    idle(4); pulse_sleep(); idle(HF_STAB + 2);
    pulse_wake(); idle(SW_DLY + 3);
    finish_run();
  end
endmodule